// File: doc/BRIEF.md
# Bit-Clock Rate Detector

This block works out the rate of a serial bit clock by counting its own cycles between successive frame strobes, which arrive at a fixed 8 kHz. It runs on the bit clock itself. Each frame period that matches one of eight supported lengths maps to a 3-bit rate code. The block locks the code the first time two frame periods in a row have the same length. After that the code stays fixed until the next reset.

From the locked code, the block derives the factor by which a downstream frequency synthesizer must multiply the bit clock to reach 16.384 MHz. That is 2048 internal cycles per frame. When the line interface runs in its time-slot (GCI-style) mode, two of the eight rates are not allowed. The block then raises an error instead of locking. A frame length that matches no supported rate also raises an error. Once the code is locked, a settle timer counts a fixed number of bit-clock cycles and then signals that the synthesizer output can be used.

Top module: `rd_ratio_detect`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, ratio_code_o, mult_o, valid_o, error_o and ready_o are all zero.
- R2: A period is the number of clock cycles from one rising edge of fsync_i to the next. The first rising edge after reset only starts the count and produces no period. A strobe held high for several cycles counts as one edge.
- R3: The rate code is assigned from the period length: 32 gives 0, 64 gives 1, 96 gives 2, 128 gives 3, 192 gives 4, 256 gives 5, 512 gives 6, 1024 gives 7.
- R4: The code is taken only when two consecutive periods are the same length. A run of periods that differ from their predecessor changes no output.
- R5: With gci_mode_i high when the confirming edge is sampled, periods of 96 and 192 (codes 2 and 4) are refused. error_o rises and valid_o stays low.
- R6: A confirmed period that matches none of the eight lengths sets error_o. This includes any period longer than 1024, where the counter saturates at 2047. ratio_code_o and mult_o keep their current values, which are zero before a lock.
- R7: Once valid_o is high, the outputs are frozen until reset. ratio_code_o, mult_o and valid_o keep their values whatever fsync_i and gci_mode_i do. error_o is cleared at the lock and stays low.
- R8: mult_o is 2048/period in unsigned fixed point with 2 fraction bits, rounded to nearest (9 bits). Codes 0 to 7 give 256, 128, 85, 64, 43, 32, 16, 8.
- R9: ready_o rises exactly 64 clock cycles after valid_o rises and then stays high until reset.
- R10: valid_o, error_o, ratio_code_o and mult_o change at the clock edge that samples the confirming rising edge of fsync_i, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | 8 kHz frame strobe, synchronous to clk_i |
| gci_mode_i | input | 1 | High selects the mode that refuses codes 2 and 4 |
| ratio_code_o | output | 3 | Locked rate code |
| mult_o | output | 9 | Multiply factor, 7 integer and 2 fraction bits |
| valid_o | output | 1 | Rate code is locked |
| error_o | output | 1 | Last confirmed period was unsupported or refused |
| ready_o | output | 1 | Settle time has elapsed since the lock |

## Verification
The lock result appears on the outputs at the same rising edge that samples the third strobe. The first strobe only arms the counter, and the second and third strobes each end one period. The bench drives each strobe for one cycle starting at a falling edge, so the very next falling edge is the first point where the result can be seen, and it reads the result there or later. Before the confirming strobe is driven, the bench also reads the outputs to show that nothing moved early. For the settle timer, the bench reads the outputs on every falling edge after the lock. ready_o must be low on each of the first 63 falling edges and high on the 64th.

// File: rtl/rd_pkg.sv
package rd_pkg;
    localparam int unsigned NUM_RATES = 8;
    localparam int unsigned CODE_W    = $clog2(NUM_RATES);

    typedef logic [CODE_W-1:0] code_t;

    // Bit-clock cycles per frame for each code, ascending rate order.
    function automatic int unsigned rate_cycles(input int unsigned code);
        case (code)
            0:       return 32;
            1:       return 64;
            2:       return 96;
            3:       return 128;
            4:       return 192;
            5:       return 256;
            6:       return 512;
            default: return 1024;
        endcase
    endfunction

    // Rates that are refused when the time-slot mode is selected.
    function automatic logic slot_mode_banned(input code_t code);
        return (code == code_t'(2)) || (code == code_t'(4));
    endfunction
endpackage

// File: rtl/rd_period_meter.sv
module rd_period_meter #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fsync_i,
    output logic             meas_stb_o,
    output logic [CNT_W-1:0] meas_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             fs;
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } meter_t;

    meter_t d, q;
    logic   rise;

    always_comb begin
        d    = q;
        rise = fsync_i & ~q.fs;
        d.fs = fsync_i;
        if (rise) begin
            d.cnt   = CNT_W'(1);
            d.armed = 1'b1;
        end else if (q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign meas_stb_o = rise & q.armed;
    assign meas_cnt_o = q.cnt;

    // An edge restarts the period count at one.
    assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise |=> (q.cnt == CNT_W'(1)));
    // A saturated count stays put until the next edge.
    assert_saturate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.cnt == CNT_MAX) |=> (q.cnt == CNT_MAX) || (q.cnt == CNT_W'(1)));
endmodule

// File: rtl/rd_rate_match.sv
module rd_rate_match
    import rd_pkg::*;
#(
    parameter int unsigned CNT_W     = 11,
    parameter int unsigned MULT_W    = 9,
    parameter int unsigned FRAME_TGT = 2048,
    parameter int unsigned MULT_FRAC = 2
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              slot_mode_i,
    output logic              hit_o,
    output logic              allowed_o,
    output code_t             code_o,
    output logic [MULT_W-1:0] mult_o
);
    logic [NUM_RATES-1:0] match;
    logic [MULT_W-1:0]    mult_tab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int unsigned CYC = rate_cycles(g);
        localparam int unsigned MV  = ((FRAME_TGT << MULT_FRAC) + CYC / 2) / CYC;
        assign match[g]    = (cnt_i == CNT_W'(CYC));
        assign mult_tab[g] = MULT_W'(MV);
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (match[i]) code_o = code_t'(i);
        end
    end

    assign hit_o     = |match;
    assign allowed_o = ~(slot_mode_i & slot_mode_banned(code_o));
    assign mult_o    = mult_tab[code_o];
endmodule

// File: rtl/rd_settle_timer.sv
module rd_settle_timer #(
    parameter int unsigned SETTLE_CYC = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic ready_o
);
    localparam int unsigned TW = $clog2(SETTLE_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } timer_t;

    timer_t d, q;

    always_comb begin
        d = q;
        if (start_i && q.cnt != LAST) d.cnt = q.cnt + TW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ready_o = (q.cnt == LAST);

    assert_ready_needs_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> start_i);
    assert_ready_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> ready_o);
endmodule

// File: rtl/rd_ratio_detect.sv
module rd_ratio_detect
    import rd_pkg::*;
#(
    parameter int unsigned FRAME_TGT  = 2048,
    parameter int unsigned MULT_FRAC  = 2,
    parameter int unsigned SETTLE_CYC = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                fsync_i,
    input  logic                gci_mode_i,
    output logic [CODE_W-1:0]   ratio_code_o,
    output logic [8:0]          mult_o,
    output logic                valid_o,
    output logic                error_o,
    output logic                ready_o
);
    localparam int unsigned CNT_W  = $clog2(rate_cycles(NUM_RATES - 1) * 2);
    localparam int unsigned MULT_W = 9;

    typedef struct packed {
        logic [CNT_W-1:0]  prev;
        logic              have_prev;
        code_t             code;
        logic [MULT_W-1:0] mult;
        logic              valid;
        logic              err;
    } lock_t;

    lock_t             d, q;
    logic              meas_stb;
    logic [CNT_W-1:0]  meas_cnt;
    logic              hit, allowed;
    code_t             cand_code;
    logic [MULT_W-1:0] cand_mult;

    rd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fsync_i    (fsync_i),
        .meas_stb_o (meas_stb),
        .meas_cnt_o (meas_cnt)
    );

    rd_rate_match #(
        .CNT_W     (CNT_W),
        .MULT_W    (MULT_W),
        .FRAME_TGT (FRAME_TGT),
        .MULT_FRAC (MULT_FRAC)
    ) u_match (
        .cnt_i       (meas_cnt),
        .slot_mode_i (gci_mode_i),
        .hit_o       (hit),
        .allowed_o   (allowed),
        .code_o      (cand_code),
        .mult_o      (cand_mult)
    );

    rd_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (q.valid),
        .ready_o (ready_o)
    );

    always_comb begin
        d = q;
        if (meas_stb && !q.valid) begin
            d.prev      = meas_cnt;
            d.have_prev = 1'b1;
            if (q.have_prev && meas_cnt == q.prev) begin
                if (hit && allowed) begin
                    d.code  = cand_code;
                    d.mult  = cand_mult;
                    d.valid = 1'b1;
                    d.err   = 1'b0;
                end else begin
                    d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ratio_code_o = q.code;
    assign mult_o       = q.mult;
    assign valid_o      = q.valid;
    assign error_o      = q.err;

    assert_lock_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> $past(meas_stb));
    assert_slot_mode_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> !($past(gci_mode_i) &&
                             (ratio_code_o == code_t'(2) || ratio_code_o == code_t'(4))));
    assert_err_before_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(error_o) |-> !valid_o);
    assert_frozen_after_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> valid_o && !error_o && $stable(ratio_code_o) && $stable(mult_o));
endmodule

// File: tb/rd_ratio_detect_tb.sv
module rd_ratio_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       gci = 1'b0;
    logic [2:0] code;
    logic [8:0] mult;
    logic       valid, err, ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rd_ratio_detect u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fsync_i      (fsync),
        .gci_mode_i   (gci),
        .ratio_code_o (code),
        .mult_o       (mult),
        .valid_o      (valid),
        .error_o      (err),
        .ready_o      (ready)
    );

    typedef struct packed {
        logic [31:0] cyc;
        logic        gci;
        logic        v;
        logic        e;
        logic [2:0]  code;
        logic [8:0]  mult;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{32'd32,   1'b0, 1'b1, 1'b0, 3'd0, 9'd256},
        '{32'd64,   1'b0, 1'b1, 1'b0, 3'd1, 9'd128},
        '{32'd96,   1'b0, 1'b1, 1'b0, 3'd2, 9'd85},
        '{32'd128,  1'b0, 1'b1, 1'b0, 3'd3, 9'd64},
        '{32'd192,  1'b0, 1'b1, 1'b0, 3'd4, 9'd43},
        '{32'd256,  1'b0, 1'b1, 1'b0, 3'd5, 9'd32},
        '{32'd512,  1'b0, 1'b1, 1'b0, 3'd6, 9'd16},
        '{32'd1024, 1'b0, 1'b1, 1'b0, 3'd7, 9'd8},
        '{32'd96,   1'b1, 1'b0, 1'b1, 3'd0, 9'd0},
        '{32'd192,  1'b1, 1'b0, 1'b1, 3'd0, 9'd0},
        '{32'd256,  1'b1, 1'b1, 1'b0, 3'd5, 9'd32},
        '{32'd32,   1'b1, 1'b1, 1'b0, 3'd0, 9'd256},
        '{32'd100,  1'b0, 1'b0, 1'b1, 3'd0, 9'd0},
        '{32'd2000, 1'b0, 1'b0, 1'b1, 3'd0, 9'd0},
        '{32'd33,   1'b0, 1'b0, 1'b1, 3'd0, 9'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One frame: strobe high for one cycle, then n-1 quiet cycles.
    task automatic frame(input int n);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic frames(input int n, input int k);
        for (int i = 0; i < k; i++) frame(n);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int any_hi;
        @(negedge clk);
        // R1: outputs zero during reset and just after release
        chk("R1 valid in reset", int'(valid), 0);
        do_reset();
        chk("R1 code", int'(code), 0);
        chk("R1 mult", int'(mult), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 error", int'(err), 0);
        chk("R1 ready", int'(ready), 0);

        // R3 R5 R6 R8: table walk, three strobes each (arm, measure, confirm)
        for (int v = 0; v < NV; v++) begin
            gci = VEC[v].gci;
            do_reset();
            frames(int'(VEC[v].cyc), 3);
            chk($sformatf("R3 code len %0d", VEC[v].cyc), int'(code), int'(VEC[v].code));
            chk($sformatf("R8 mult len %0d", VEC[v].cyc), int'(mult), int'(VEC[v].mult));
            chk($sformatf("R5 valid len %0d gci %0d", VEC[v].cyc, VEC[v].gci),
                int'(valid), int'(VEC[v].v));
            chk($sformatf("R6 error len %0d gci %0d", VEC[v].cyc, VEC[v].gci),
                int'(err), int'(VEC[v].e));
        end
        gci = 1'b0;

        // R4: alternating lengths never confirm
        do_reset();
        frame(64); frame(128); frame(64); frame(128);
        chk("R4 no lock on differing periods", int'(valid), 0);
        chk("R4 no error on differing periods", int'(err), 0);

        // R2: strobe held high counts once; 64-cycle periods lock code 1
        do_reset();
        for (int i = 0; i < 3; i++) begin
            fsync = 1'b1;
            repeat (5) @(negedge clk);
            fsync = 1'b0;
            repeat (59) @(negedge clk);
        end
        chk("R2 long strobe lock", int'(valid), 1);
        chk("R2 long strobe code", int'(code), 1);

        // R6 then R7: error clears at lock, then frozen
        do_reset();
        frames(100, 3);
        chk("R6 unlisted error", int'(err), 1);
        chk("R6 code unchanged", int'(code), 0);
        frames(128, 3);
        chk("R7 lock after error", int'(valid), 1);
        chk("R7 error cleared", int'(err), 0);
        chk("R7 code 3", int'(code), 3);
        gci = 1'b1;
        frames(64, 4);
        frames(96, 3);
        chk("R7 code frozen", int'(code), 3);
        chk("R7 mult frozen", int'(mult), 64);
        chk("R7 valid held", int'(valid), 1);
        chk("R7 error stays low", int'(err), 0);
        gci = 1'b0;

        // R10 and R9: lock timing and settle count
        do_reset();
        frame(64); frame(64);
        chk("R10 no lock before confirming strobe", int'(valid), 0);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        chk("R10 lock on confirming edge", int'(valid), 1);
        chk("R9 ready low at lock", int'(ready), 0);
        any_hi = 0;
        for (int i = 1; i < 64; i++) begin
            @(negedge clk);
            if (ready) any_hi++;
        end
        chk("R9 ready low for 63 cycles", any_hi, 0);
        @(negedge clk);
        chk("R9 ready at 64 cycles", int'(ready), 1);
        repeat (10) @(negedge clk);
        chk("R9 ready held", int'(ready), 1);

        summary();
        $finish;
    end
endmodule